// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address of a four-beat burst for a synchronous burst memory. A load strobe captures a start address and an order selection. Each cycle with the advance input high then moves the burst one beat on. In linear order the beats count upward from the start address and wrap around the burst boundary. In interleaved order each beat is the start address XOR the beat number, so the beats form the pairwise-swapped pattern that some cache line fills expect. The upper address bits, the storage array and the data path belong to other blocks.

A two-state machine sets the control flow. After reset it is in `SEQ_IDLE`, where no burst has been loaded. The transition `idle_to_burst`, taken on a load, enters `SEQ_BURST`. In that state the self-transition `burst_step` is taken on advance, and `burst_reload` is taken on a new load, which restarts the burst from the new start address even in the middle of a burst. The burst width is the parameter `BURST_AW`, with a default of 2 bits and 4 beats.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the burst address output is 0 and the sequencer is idle.
- R2: In the cycle after a clock edge that samples `load_i` high, `burst_addr_o` equals the `start_addr_i` value sampled at that edge, and the beat count is 0.
- R3: With `order_sel_i` = 0 captured at load (linear order), beat n is (start + n) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R4: With `order_sel_i` = 1 captured at load (interleaved order), beat n is start XOR n. Start 0 gives 0,1,2,3; start 1 gives 1,0,3,2; start 2 gives 2,3,0,1; start 3 gives 3,2,1,0.
- R5: The beat count moves on only at edges where `adv_i` is high. When both `adv_i` and `load_i` are low, `burst_addr_o` holds its value.
- R6: An advance taken on the fourth beat wraps the burst back to the start address, and the sequence then repeats.
- R7: A load restarts the burst from its new start address at any beat and takes priority over an advance sampled at the same edge.
- R8: The order is captured only at load. A change of `order_sel_i` during a burst has no effect until the next load.
- R9: Before the first load after reset, an advance is ignored and `burst_addr_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst from `start_addr_i` |
| start_addr_i | input | BURST_AW | Start address of the burst |
| adv_i | input | 1 | Move on to the next beat |
| order_sel_i | input | 1 | Order selection captured at load: 0 linear, 1 interleaved |
| burst_addr_o | output | BURST_AW | Current burst address |

## Verification
The bench builds the block with the default `BURST_AW` of 2. This gives the four-beat burst whose full interleaved table can be written out and compared beat by beat. It covers every start address in both orders, including the wrap after the fourth beat. At this width the bench can also land a reload on every beat position, and it can change the order input in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_e;

    typedef enum logic [0:0] {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       adv_i,
    output logic       cap_o,
    output logic       step_o,
    output seq_state_e state_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (load_i) state_d = SEQ_BURST;  // idle_to_burst
            SEQ_BURST: state_d = SEQ_BURST;              // burst_step / burst_reload
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cap_o  = 1'b0;
        step_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                cap_o  = load_i;
                step_o = 1'b0;
            end
            SEQ_BURST: begin
                cap_o  = load_i;
                step_o = adv_i && !load_i;
            end
            default: begin
                cap_o  = 1'b0;
                step_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R2: a load always leaves the machine in the burst state
    assert_enter_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q == SEQ_BURST));

    // R1: the burst state is never left once entered
    assert_stay_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BURST) |=> (state_q == SEQ_BURST));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BURST_AW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                inc_i,
    output logic [BURST_AW-1:0] beat_o
);

    localparam logic [BURST_AW-1:0] LAST_BEAT = '1;

    logic [BURST_AW-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     beat_q <= '0;
        else if (clr_i) beat_q <= '0;
        else if (inc_i) beat_q <= beat_q + 1'b1;
    end

    assign beat_o = beat_q;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(beat_q));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && beat_q == LAST_BEAT) |=> (beat_q == '0));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (beat_q == '0));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
#(
    parameter int BURST_AW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic [BURST_AW-1:0] start_i,
    input  logic                order_sel_i,
    input  logic [BURST_AW-1:0] beat_i,
    output order_e              order_o,
    output logic [BURST_AW-1:0] addr_o
);

    logic [BURST_AW-1:0] start_q;
    order_e              order_q;
    logic [BURST_AW-1:0] lin_addr;
    logic [BURST_AW-1:0] il_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            order_q <= ORD_LINEAR;
        end else if (cap_i) begin
            start_q <= start_i;
            order_q <= order_e'(order_sel_i);
        end
    end

    // linear: wrapping sum
    assign lin_addr = start_q + beat_i;

    // interleaved: per-bit swap of the start address
    for (genvar b = 0; b < BURST_AW; b++) begin : g_il_bit
        assign il_addr[b] = start_q[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_q)
            ORD_LINEAR:     addr_o = lin_addr;
            ORD_INTERLEAVE: addr_o = il_addr;
            default:        addr_o = lin_addr;
        endcase
    end

    assign order_o = order_q;

    assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(order_q) && $stable(start_q)));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int BURST_AW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [BURST_AW-1:0] start_addr_i,
    input  logic                adv_i,
    input  logic                order_sel_i,
    output logic [BURST_AW-1:0] burst_addr_o
);

    logic                cap;
    logic                step;
    seq_state_e          state;
    logic [BURST_AW-1:0] beat;
    order_e              order;

    burst_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .cap_o   (cap),
        .step_o  (step),
        .state_o (state)
    );

    burst_beat_ctr #(.BURST_AW(BURST_AW)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cap),
        .inc_i  (step),
        .beat_o (beat)
    );

    burst_addr_map #(.BURST_AW(BURST_AW)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (cap),
        .start_i     (start_addr_i),
        .order_sel_i (order_sel_i),
        .beat_i      (beat),
        .order_o     (order),
        .addr_o      (burst_addr_o)
    );

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (burst_addr_o == $past(start_addr_i)));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_BURST && adv_i && !load_i && order == ORD_LINEAR)
        |=> (burst_addr_o == $past(burst_addr_o) + 1'b1));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && !load_i) |=> (burst_addr_o == '0));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(burst_addr_o));

endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [1:0] start_addr_i = 2'd0;
    logic       adv_i = 1'b0;
    logic       order_sel_i = 1'b0;
    logic [1:0] burst_addr_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    item_t q[$];

    // bench model state
    bit       m_active = 1'b0;
    bit       m_il     = 1'b0;
    bit [1:0] m_start  = 2'd0;
    bit [1:0] m_beat   = 2'd0;
    bit [1:0] il_tbl [4][4];

    always #2.5 clk = ~clk;

    burst_addr_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .start_addr_i (start_addr_i),
        .adv_i        (adv_i),
        .order_sel_i  (order_sel_i),
        .burst_addr_o (burst_addr_o)
    );

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: burst_addr_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes expected address after the edge
    task automatic cyc(input bit ld, input bit [1:0] s, input bit adv,
                       input bit md, input string tag);
        item_t it;
        @(negedge clk);
        load_i       = ld;
        start_addr_i = s;
        adv_i        = adv;
        order_sel_i  = md;
        if (ld) begin
            m_active = 1'b1;
            m_il     = md;
            m_start  = s;
            m_beat   = 2'd0;
        end else if (adv && m_active) begin
            m_beat = m_beat + 2'd1;
        end
        if (!m_active)  it.exp = 2'd0;
        else if (m_il)  it.exp = il_tbl[m_start][m_beat];
        else            it.exp = m_start + m_beat;
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(burst_addr_o, it.exp, it.tag);
        end
    end

    initial begin
        // interleaved lookup table (R4)
        il_tbl[0] = '{2'd0, 2'd1, 2'd2, 2'd3};
        il_tbl[1] = '{2'd1, 2'd0, 2'd3, 2'd2};
        il_tbl[2] = '{2'd2, 2'd3, 2'd0, 2'd1};
        il_tbl[3] = '{2'd3, 2'd2, 2'd1, 2'd0};

        repeat (3) @(posedge clk);
        #1 check(burst_addr_o, 2'd0, "R1 reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check(burst_addr_o, 2'd0, "R1 after reset");

        // R9: advance before any load
        for (int i = 0; i < 3; i++) cyc(0, 2'd2, 1, 0, "R9 adv idle");

        // R3 linear and R4 interleaved, all starts, with wrap R6
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1, 2'(s), 0, md[0], "R2 load");
                for (int b = 1; b < 4; b++)
                    cyc(0, 2'd0, 1, md[0], md ? "R4 interleave" : "R3 linear");
                cyc(0, 2'd0, 1, md[0], "R6 wrap");
                cyc(0, 2'd0, 1, md[0], "R6 repeat");
            end
        end

        // R5: hold without advance
        cyc(1, 2'd1, 0, 0, "R2 load");
        cyc(0, 2'd3, 0, 1, "R5 hold");
        cyc(0, 2'd3, 0, 1, "R5 hold");
        cyc(0, 2'd0, 1, 0, "R5 step");
        cyc(0, 2'd0, 0, 0, "R5 hold");

        // R7: reload mid-burst with advance high, at every beat position
        for (int p = 0; p < 4; p++) begin
            cyc(1, 2'd0, 0, 1, "R2 load");
            for (int b = 0; b < p; b++) cyc(0, 2'd0, 1, 1, "R4 interleave");
            cyc(1, 2'd3, 1, 0, "R7 reload priority");
            cyc(0, 2'd0, 1, 0, "R7 after reload");
        end

        // R8: order input change mid-burst ignored
        cyc(1, 2'd1, 0, 0, "R2 load");
        cyc(0, 2'd0, 1, 1, "R8 order change");
        cyc(0, 2'd0, 1, 1, "R8 order change");
        cyc(0, 2'd0, 1, 1, "R8 order change");
        cyc(1, 2'd1, 0, 1, "R2 load");
        cyc(0, 2'd0, 1, 0, "R8 order change");
        cyc(0, 2'd0, 1, 0, "R8 order change");

        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule